// File: doc/BRIEF.md
# Pipelined Bus Access Slave Controller

This block is a memory slave on a synchronous channel with split address and data buses. A master opens an access by pulsing a request strobe with the address, a read/write line and a two-bit width code. The slave answers after a fixed number of wait cycles with ready, or with error when the address falls outside its window or the width code is reserved. On every cycle of a multi-cycle access that is not its last, the slave raises pipeline-enable. The first such cycle also loads the access into a primary register, so the master may take its address off the bus on the next cycle.

While the primary access is running, the master may present a second access with the pipelined flag raised and the request strobe low. The slave captures and decodes it and counts its wait cycles. It drives no data, raises no ready or error, and commits nothing for it. If the master raises the strobe in the cycle after the primary access ends, the pending access becomes primary and may finish in that same cycle. If the flag falls first, or the strobe does not come in that cycle, the pending access is dropped without a trace.

Storage is a small word array. Reads always return the whole aligned word. Writes honour byte and halfword widths through lane enables.

Top module: `pbs_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, rdy_o, err_o and pen_o are low and rdata_o is zero; reset also clears every storage word to zero.
- R2: A primary access started by req_i (with no primary access running) completes exactly WAIT_CYC cycles later (WAIT_CYC=0 means the same cycle). pen_o is high on each earlier cycle of it, and address, rd_i and size_i are used as they were in the strobe cycle, even if the bus changes afterwards.
- R3: An access hits when addr_i lies in [BASE_ADDR, BASE_ADDR+4*DEPTH) and size_i is not 2'b11. A hit completes with rdy_o; a miss completes with err_o instead, writes nothing, and returns zero data.
- R4: A read that hits returns on rdata_o the whole word at index addr[IDX_W+1:2], whatever its width code; rdata_o is zero on every cycle without rdy_o.
- R5: rd_i=1 means read and rd_i=0 means write. Write width code 2'b00 writes all four bytes. Code 2'b01 writes byte lane addr[1:0], where lane k is bits 8k+7:8k. Code 2'b10 writes lanes 3:2 when addr[1]=1 and lanes 1:0 otherwise. The write takes wdata_i from the rdy_o cycle and is the only state change.
- R6: With pipe_i=1 and req_i=0 during a primary access, one pending access is captured; it raises no rdy_o or err_o, drives no rdata_o and does not disturb the primary access's result.
- R7: req_i in the cycle after the primary access completes promotes the pending access. It uses the captured address and control, not the current bus. Its wait cycles spent pending count, so it completes in the strobe cycle if it waited WAIT_CYC cycles, otherwise later with pen_o high. pipe_i in the cycle after promotion starts no new capture.
- R8: A pending access is dropped if pipe_i falls before promotion, or if req_i is low in the cycle after the primary access completes. A dropped access never completes, never writes, and a later req_i starts a fresh access from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Primary request strobe |
| pipe_i | input | 1 | Pipelined-address flag |
| addr_i | input | 32 | Byte address |
| rd_i | input | 1 | 1 read, 0 write |
| size_i | input | 2 | Width code: 00 word, 01 byte, 10 halfword, 11 reserved |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rdy_o |
| rdy_o | output | 1 | Access completed successfully |
| err_o | output | 1 | Access completed with error |
| pen_o | output | 1 | Pipeline enable: primary access latched, bus may be released |

## Verification
The bench scrambles the address, direction and width lines after the strobe cycle. A slave that failed to latch the primary access would return the wrong word or finish with an error. A pending read is promoted while the bus shows an unmapped address, and it must finish in the strobe cycle. A slave that used the live bus or restarted the wait count would raise an error or answer late. A second promotion arrives after only one pending cycle and must take one extra wait cycle. Two cancellation cases follow, one where the strobe never comes and one where the flag drops early, each with a pending write. A slave that leaked the write or promoted a dead access would corrupt the word read back afterwards or finish the fresh access early.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int unsigned PBS_AW = 32;
  localparam int unsigned PBS_DW = 32;
  localparam int unsigned PBS_NB = PBS_DW / 8;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef struct packed {
    logic [PBS_AW-1:0] addr;
    logic              rd;
    size_e             size;
    logic              hit;
  } acc_t;

  function automatic logic [PBS_NB-1:0] lane_en(input size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_WORD: lane_en = '1;
      SZ_BYTE: lane_en = PBS_NB'(1) << lo;
      SZ_HALF: lane_en = lo[1] ? PBS_NB'(4'b1100) : PBS_NB'(4'b0011);
      default: lane_en = '0;
    endcase
  endfunction
endpackage

// File: rtl/pbs_decode.sv
module pbs_decode import pbs_pkg::*; #(
  parameter int unsigned DEPTH     = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic [PBS_AW-1:0] addr_i,
  input  size_e             size_i,
  output logic              hit_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned TOP_L = IDX_W + 2;

  logic unused_lo;
  assign unused_lo = ^addr_i[TOP_L-1:0];

  assign hit_o = (addr_i[PBS_AW-1:TOP_L] == BASE_ADDR[PBS_AW-1:TOP_L]) && (size_i != SZ_RSVD);
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl import pbs_pkg::*; #(
  parameter int unsigned WAIT_CYC = 2,
  parameter bit          PIPE_EN  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pipe_i,
  input  acc_t in_acc_i,
  output logic done_o,
  output acc_t cur_acc_o,
  output logic pen_o
);
  localparam int unsigned     CNT_W   = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYC);

  logic             prim_v, pend_v, done_q, promo_q;
  acc_t             prim_acc, pend_acc;
  logic [CNT_W-1:0] prim_cnt, pend_cnt, cur_cnt;
  logic             start, act, capture, cancel;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_W'(1);
  endfunction

  // primary latched > pending captured > live bus
  assign start     = req_i & ~prim_v;
  assign act       = prim_v | start;
  assign cur_acc_o = prim_v ? prim_acc : (pend_v ? pend_acc : in_acc_i);
  assign cur_cnt   = prim_v ? prim_cnt : (pend_v ? pend_cnt : '0);
  assign done_o    = act & (cur_cnt == CNT_MAX);
  assign pen_o     = PIPE_EN & act & ~done_o;
  assign capture   = PIPE_EN & pipe_i & ~req_i & prim_v & ~pend_v & ~promo_q;
  assign cancel    = pend_v & ~req_i & (done_q | ~pipe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_v   <= 1'b0;
      prim_acc <= '0;
      prim_cnt <= '0;
    end else if (done_o) begin
      prim_v   <= 1'b0;
    end else if (start) begin
      prim_v   <= 1'b1;
      prim_acc <= cur_acc_o;
      prim_cnt <= sat_inc(cur_cnt);
    end else if (prim_v) begin
      prim_cnt <= sat_inc(prim_cnt);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v   <= 1'b0;
      pend_acc <= '0;
      pend_cnt <= '0;
    end else if (pend_v && (start || cancel)) begin
      pend_v   <= 1'b0;
    end else if (pend_v) begin
      pend_cnt <= sat_inc(pend_cnt);
    end else if (capture) begin
      pend_v   <= 1'b1;
      pend_acc <= in_acc_i;
      pend_cnt <= sat_inc('0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      promo_q <= 1'b0;
    end else begin
      done_q  <= done_o;
      promo_q <= start & pend_v;
    end
  end

  // R2: once pen_o is seen the access lives in the primary register
  a_r2_latched_after_pen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_o |=> prim_v);
  // R2: latched access stays frozen until it completes
  a_r2_primary_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_v && !done_o) |=> $stable(prim_acc));
  // R7: promotion only right after a primary completion
  a_r7_promote_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && pend_v) |-> done_q);
  // R8: missing strobe or dropped flag kills the pending access
  a_r8_cancel_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && !req_i && (done_q || !pipe_i)) |=> !pend_v);
endmodule

// File: rtl/pbs_mem.sv
module pbs_mem import pbs_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PBS_NB-1:0] be_i,
  input  logic [PBS_DW-1:0] wdata_i,
  output logic [PBS_DW-1:0] rdata_o
);
  for (genvar l = 0; l < PBS_NB; l++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
      end else if (we_i && be_i[l]) begin
        lane_q[idx_i] <= wdata_i[8*l +: 8];
      end
    end

    assign rdata_o[8*l +: 8] = lane_q[idx_i];
  end
endmodule

// File: rtl/pbs_top.sv
module pbs_top import pbs_pkg::*; #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned WAIT_CYC  = 2,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter bit          PIPE_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              pipe_i,
  input  logic [PBS_AW-1:0] addr_i,
  input  logic              rd_i,
  input  logic [1:0]        size_i,
  input  logic [PBS_DW-1:0] wdata_i,
  output logic [PBS_DW-1:0] rdata_o,
  output logic              rdy_o,
  output logic              err_o,
  output logic              pen_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  acc_t              in_acc, cur_acc;
  logic              dec_hit, done;
  logic [PBS_DW-1:0] mem_rdata;
  logic              mem_we;
  logic              unused_hi;

  pbs_decode #(.DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .size_i (size_e'(size_i)),
    .hit_o  (dec_hit)
  );

  assign in_acc = '{addr: addr_i, rd: rd_i, size: size_e'(size_i), hit: dec_hit};

  pbs_ctrl #(.WAIT_CYC(WAIT_CYC), .PIPE_EN(PIPE_EN)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .pipe_i    (pipe_i),
    .in_acc_i  (in_acc),
    .done_o    (done),
    .cur_acc_o (cur_acc),
    .pen_o     (pen_o)
  );

  assign unused_hi = ^cur_acc.addr[PBS_AW-1:IDX_W+2];
  assign rdy_o     = done & cur_acc.hit;
  assign err_o     = done & ~cur_acc.hit;
  assign mem_we    = rdy_o & ~cur_acc.rd;

  pbs_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .idx_i   (cur_acc.addr[IDX_W+1:2]),
    .be_i    (lane_en(cur_acc.size, cur_acc.addr[1:0])),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  assign rdata_o = (rdy_o && cur_acc.rd) ? mem_rdata : '0;

  // R3: one completion flavour per access
  a_r3_rdy_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdy_o && err_o));
  // R4: data bus quiet outside ready cycles
  a_r4_rdata_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> (rdata_o == '0));
endmodule

// File: tb/pbs_top_tb_top.sv
`timescale 1ns/100ps
module pbs_top_tb_top;
  localparam int W = 2;

  typedef struct packed {
    logic        rd;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] wd;
    logic        er;
    logic [31:0] rdat;
  } vec_t;

  localparam vec_t VT [15] = '{
    '{1'b0, 2'b00, 32'h0000_1000, 32'hA5A5_0001, 1'b0, 32'h0},
    '{1'b0, 2'b00, 32'h0000_103C, 32'hDEAD_BEEF, 1'b0, 32'h0},
    '{1'b1, 2'b00, 32'h0000_1000, 32'h0,         1'b0, 32'hA5A5_0001},
    '{1'b1, 2'b00, 32'h0000_103C, 32'h0,         1'b0, 32'hDEAD_BEEF},
    '{1'b0, 2'b01, 32'h0000_1001, 32'h0000_7700, 1'b0, 32'h0},
    '{1'b1, 2'b01, 32'h0000_1000, 32'h0,         1'b0, 32'hA5A5_7701},
    '{1'b0, 2'b10, 32'h0000_1002, 32'h1234_0000, 1'b0, 32'h0},
    '{1'b1, 2'b00, 32'h0000_1000, 32'h0,         1'b0, 32'h1234_7701},
    '{1'b0, 2'b00, 32'h0000_2000, 32'hFFFF_FFFF, 1'b1, 32'h0},
    '{1'b1, 2'b00, 32'h0000_0FFC, 32'h0,         1'b1, 32'h0},
    '{1'b1, 2'b11, 32'h0000_1000, 32'h0,         1'b1, 32'h0},
    '{1'b0, 2'b11, 32'h0000_1004, 32'h9999_9999, 1'b1, 32'h0},
    '{1'b1, 2'b00, 32'h0000_1004, 32'h0,         1'b0, 32'h0},
    '{1'b0, 2'b01, 32'h0000_103F, 32'h5500_0000, 1'b0, 32'h0},
    '{1'b1, 2'b00, 32'h0000_103C, 32'h0,         1'b0, 32'h55AD_BEEF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, pipe_i = 1'b0, rd_i = 1'b1;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rdy_o, err_o, pen_o;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pbs_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .pipe_i(pipe_i),
    .addr_i(addr_i), .rd_i(rd_i), .size_i(size_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rdy_o(rdy_o), .err_o(err_o), .pen_o(pen_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic rq, input logic pp, input logic [31:0] a,
                     input logic rd, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk_i);
    req_i = rq; pipe_i = pp; addr_i = a; rd_i = rd; size_i = sz; wdata_i = wd;
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 32'hFFFF_FFF0, 1'b1, 2'b00, wdata_i);
  endtask

  task automatic simple(input vec_t v);
    for (int k = 0; k <= W; k++) begin
      if (k == 0) cyc(1'b1, 1'b0, v.a, v.rd, v.sz, v.wd);
      else        cyc(1'b0, 1'b0, 32'hDEAD_0000, ~v.rd, 2'b11, v.wd);
      if (k < W) begin
        chk("R2 pen before completion", 32'(pen_o), 32'd1);
        chk("R2 no early rdy/err", 32'({rdy_o, err_o}), 32'd0);
      end else begin
        chk("R3 rdy", 32'(rdy_o), 32'(!v.er));
        chk("R3 err", 32'(err_o), 32'(v.er));
        chk("R4 R5 rdata", rdata_o, (v.rd && !v.er) ? v.rdat : 32'h0);
      end
    end
    idle();
  endtask

  function automatic vec_t wr(input logic [31:0] a, input logic [31:0] d);
    return '{1'b0, 2'b00, a, d, 1'b0, 32'h0};
  endfunction

  function automatic vec_t rdv(input logic [31:0] a, input logic [31:0] d);
    return '{1'b1, 2'b00, a, 32'h0, 1'b0, d};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 rdy in reset", 32'(rdy_o), 32'd0);
    chk("R1 pen in reset", 32'(pen_o), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    chk("R1 outputs after reset", 32'({rdy_o, err_o, pen_o}), 32'd0);
    chk("R1 rdata after reset", rdata_o, 32'h0);

    // table walk: R2..R5
    for (int i = 0; i < 15; i++) simple(VT[i]);

    simple(wr(32'h0000_1004, 32'h1111_1111));
    simple(wr(32'h0000_1008, 32'h2222_2222));
    simple(wr(32'h0000_1010, 32'h4444_4444));
    simple(wr(32'h0000_1014, 32'h5555_5555));

    // promotion with same-cycle completion: R6, R7
    cyc(1'b1, 1'b0, 32'h0000_1008, 1'b1, 2'b00, 32'h0);
    chk("R2 pen primary", 32'(pen_o), 32'd1);
    cyc(1'b0, 1'b1, 32'h0000_1004, 1'b1, 2'b00, 32'h0);
    chk("R6 pending silent rdy/err", 32'({rdy_o, err_o}), 32'd0);
    chk("R6 pending silent rdata", rdata_o, 32'h0);
    cyc(1'b0, 1'b1, 32'h0000_1004, 1'b1, 2'b00, 32'h0);
    chk("R6 primary result kept", rdata_o, 32'h2222_2222);
    cyc(1'b1, 1'b1, 32'h0000_0000, 1'b1, 2'b00, 32'h0);
    chk("R7 promoted done in strobe cycle", 32'({rdy_o, err_o}), 32'b10);
    chk("R7 promoted uses captured addr", rdata_o, 32'h1111_1111);
    cyc(1'b0, 1'b1, 32'h0000_0000, 1'b1, 2'b00, 32'h0);
    chk("R7 flag after promotion ignored", 32'({rdy_o, err_o, pen_o}), 32'd0);
    idle();

    // promotion needing one more wait: R7
    cyc(1'b1, 1'b0, 32'h0000_100C, 1'b0, 2'b00, 32'h3333_0000);
    cyc(1'b0, 1'b0, 32'hDEAD_0000, 1'b1, 2'b11, 32'h3333_0000);
    cyc(1'b0, 1'b1, 32'h0000_100C, 1'b1, 2'b00, 32'h3333_0000);
    chk("R5 write completes", 32'(rdy_o), 32'd1);
    cyc(1'b1, 1'b1, 32'hDEAD_0000, 1'b0, 2'b11, 32'h0);
    chk("R7 short pending not done", 32'({rdy_o, err_o}), 32'd0);
    chk("R7 short pending pen", 32'(pen_o), 32'd1);
    cyc(1'b0, 1'b0, 32'hDEAD_0000, 1'b0, 2'b11, 32'h0);
    chk("R7 late completion rdy", 32'(rdy_o), 32'd1);
    chk("R7 late completion data", rdata_o, 32'h3333_0000);
    idle();

    // cancel by missing strobe: R8
    cyc(1'b1, 1'b0, 32'h0000_1010, 1'b1, 2'b00, 32'h0);
    cyc(1'b0, 1'b1, 32'h0000_1014, 1'b0, 2'b00, 32'hBAD0_0000);
    cyc(1'b0, 1'b1, 32'h0000_1014, 1'b0, 2'b00, 32'hBAD0_0000);
    chk("R8 primary data", rdata_o, 32'h4444_4444);
    cyc(1'b0, 1'b1, 32'h0000_1014, 1'b0, 2'b00, 32'hBAD0_0000);
    chk("R8 no strobe no completion", 32'({rdy_o, err_o}), 32'd0);
    cyc(1'b0, 1'b0, 32'h0000_1014, 1'b0, 2'b00, 32'hBAD0_0000);
    chk("R8 still nothing", 32'({rdy_o, err_o}), 32'd0);
    idle();
    simple(rdv(32'h0000_1014, 32'h5555_5555));

    // cancel by flag drop: R8
    cyc(1'b1, 1'b0, 32'h0000_1010, 1'b1, 2'b00, 32'h0);
    cyc(1'b0, 1'b1, 32'h0000_1014, 1'b0, 2'b00, 32'hBAD1_0000);
    cyc(1'b0, 1'b0, 32'hDEAD_0000, 1'b1, 2'b11, 32'hBAD1_0000);
    chk("R8 primary data flag drop", rdata_o, 32'h4444_4444);
    cyc(1'b1, 1'b0, 32'h0000_1010, 1'b1, 2'b00, 32'h0);
    chk("R8 fresh access not instant", 32'({rdy_o, err_o}), 32'd0);
    chk("R8 fresh access pen", 32'(pen_o), 32'd1);
    cyc(1'b0, 1'b0, 32'hDEAD_0000, 1'b0, 2'b11, 32'h0);
    chk("R8 fresh access wait", 32'(rdy_o), 32'd0);
    cyc(1'b0, 1'b0, 32'hDEAD_0000, 1'b0, 2'b11, 32'h0);
    chk("R8 fresh access data", rdata_o, 32'h4444_4444);
    idle();
    simple(rdv(32'h0000_1014, 32'h5555_5555));

    // reset mid-access: R1
    cyc(1'b1, 1'b0, 32'h0000_1000, 1'b1, 2'b00, 32'h0);
    req_i = 1'b0;
    rst_ni = 1'b0;
    #0.5;
    chk("R1 reset aborts access", 32'({rdy_o, err_o, pen_o}), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    chk("R1 quiet after release", 32'({rdy_o, err_o, pen_o}), 32'd0);
    simple(rdv(32'h0000_1000, 32'h0));

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule